// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers interrupt requests from two 8-bit local banks and one group of 8 remappable sources, and presents them to a processor as two interrupt lines, one per local bank. The remappable group does not reach the processor directly. It passes through two separately masked paths, and each path folds into one fixed bit of a local bank: bit 7 of bank 0 and bit 3 of bank 1. Software handles an interrupt by reading the bank status, then the map status, and scanning the set bits. The hardware does no vectoring and no prioritisation.

Bank 1 also holds two timer-event latches. A one-cycle event pulse sets a latch, and the latch stays set until software clears it through a write-only clear register. Every other status bit is a level copy of its input. A byte-wide register port, with a combinational read path, gives access to the status and mask registers. Each processor line is the OR of its bank's masked status, taken through one register stage.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset all four mask registers read 0x00, both timer latches are clear, and `cpu_irq_o` is 2'b00.
- R2: Reading offset 0x0 returns bank-0 status. Bits 6:0 equal `src_l0_i[6:0]` in the same cycle. Input `src_l0_i[7]` has no effect, because that bit position is taken by the map path (R5).
- R3: Reading offset 0x2 returns bank-1 status. Bits 7:6 and 2:0 equal the same bits of `src_l1_i`. Inputs `src_l1_i[5:3]` have no effect, because those positions are taken by the map path (R6) and the timer latches (R7).
- R4: Reading offset 0x4 returns `src_map_i` in the same cycle.
- R5: Bank-0 status bit 7 is 1 exactly when `src_map_i` AND the map mask 0 register (offset 0x5) is non-zero.
- R6: Bank-1 status bit 3 is 1 exactly when `src_map_i` AND the map mask 1 register (offset 0x9) is non-zero.
- R7: A 1 on `tmr_evt_i[0]` or `tmr_evt_i[1]` at a clock edge sets bank-1 status bit 4 or bit 5 respectively. The bit stays set, whatever the inputs do, until it is cleared (R8).
- R8: A write to offset 0x8 clears the bank-1 bit 4 latch when data bit 0 is 1, and the bit 5 latch when data bit 1 is 1. An event in the same cycle takes priority over the clear. Offset 0x8 reads 0x00.
- R9: At every clock edge, `cpu_irq_o[b]` takes the OR of bank b's status AND bank b's mask, using the values present before that edge.
- R10: The masks at offsets 0x1 (bank 0), 0x3 (bank 1), 0x5 and 0x9 can be written and read back. Writes to the status offsets 0x0, 0x2 and 0x4 change no register. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_l0_i | input | 8 | Bank-0 level sources |
| src_l1_i | input | 8 | Bank-1 level sources |
| src_map_i | input | 8 | Remappable level sources |
| tmr_evt_i | input | 2 | Timer event pulses, latched |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| cpu_irq_o | output | 2 | Processor interrupt lines, bank 0 in bit 0 |

## Verification
Read data depends combinationally on the current inputs and register state. The bench therefore samples a read 1 ns after it sets the offset, in the low clock phase, with no clock edge in between. A mask write or a timer event takes effect at the next rising edge and can be seen at the following falling edge. The interrupt lines lag one edge behind status and mask, so at each edge the bench predicts their value from its model before the update, then compares at the falling edge. Because of that extra register, a timer event appears on a line only two edges after the pulse.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NBANK = 2;
  localparam int NTMR = 2;

  localparam logic [AW-1:0] OFS_L0_STAT = 4'h0;
  localparam logic [AW-1:0] OFS_L0_MASK = 4'h1;
  localparam logic [AW-1:0] OFS_L1_STAT = 4'h2;
  localparam logic [AW-1:0] OFS_L1_MASK = 4'h3;
  localparam logic [AW-1:0] OFS_MAP_STAT = 4'h4;
  localparam logic [AW-1:0] OFS_MAP_MASK0 = 4'h5;
  localparam logic [AW-1:0] OFS_TMR_CLR = 4'h8;
  localparam logic [AW-1:0] OFS_MAP_MASK1 = 4'h9;

  localparam int L0_MAP_BIT = 7;
  localparam int L1_MAP_BIT = 3;
  localparam int L1_TMR_LSB = 4;
endpackage

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
  import irq_cascade_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NTMR-1:0] tmr_evt_i,
  input  logic [DW-1:0] l0_stat_i,
  input  logic [DW-1:0] l1_stat_i,
  input  logic [DW-1:0] map_stat_i,
  output logic [DW-1:0] l0_mask_o,
  output logic [DW-1:0] l1_mask_o,
  output logic [DW-1:0] map_mask0_o,
  output logic [DW-1:0] map_mask1_o,
  output logic [NTMR-1:0] tmr_lat_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] l0_mask_q, l1_mask_q, mm0_q, mm1_q;
  logic [NTMR-1:0] tmr_lat_q, tmr_clr;

  assign tmr_clr = (we_i && addr_i == OFS_TMR_CLR) ? wdata_i[NTMR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l0_mask_q <= '0;
      l1_mask_q <= '0;
      mm0_q     <= '0;
      mm1_q     <= '0;
      tmr_lat_q <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          OFS_L0_MASK:   l0_mask_q <= wdata_i;
          OFS_L1_MASK:   l1_mask_q <= wdata_i;
          OFS_MAP_MASK0: mm0_q     <= wdata_i;
          OFS_MAP_MASK1: mm1_q     <= wdata_i;
          default: ;
        endcase
      end
      // set beats clear so an event is never lost
      tmr_lat_q <= (tmr_lat_q & ~tmr_clr) | tmr_evt_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_L0_STAT:   rdata_o = l0_stat_i;
      OFS_L0_MASK:   rdata_o = l0_mask_q;
      OFS_L1_STAT:   rdata_o = l1_stat_i;
      OFS_L1_MASK:   rdata_o = l1_mask_q;
      OFS_MAP_STAT:  rdata_o = map_stat_i;
      OFS_MAP_MASK0: rdata_o = mm0_q;
      OFS_MAP_MASK1: rdata_o = mm1_q;
      default:       rdata_o = '0;
    endcase
  end

  assign l0_mask_o   = l0_mask_q;
  assign l1_mask_o   = l1_mask_q;
  assign map_mask0_o = mm0_q;
  assign map_mask1_o = mm1_q;
  assign tmr_lat_o   = tmr_lat_q;

  // R7
  tmr0_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i[0] |=> tmr_lat_q[0]);
  // R7
  tmr1_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i[1] |=> tmr_lat_q[1]);
  // R8
  tmr0_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_TMR_CLR && wdata_i[0] && !tmr_evt_i[0]) |=> !tmr_lat_q[0]);
  // R10
  stat_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == OFS_L0_STAT || addr_i == OFS_L1_STAT || addr_i == OFS_MAP_STAT))
    |=> ($stable(l0_mask_q) && $stable(l1_mask_q) && $stable(mm0_q) && $stable(mm1_q)
         && ($past(tmr_evt_i) != 0 || $stable(tmr_lat_q))));
endmodule

// File: rtl/irq_cascade_status.sv
module irq_cascade_status
  import irq_cascade_pkg::*;
(
  input  logic [DW-1:0]   src_l0_i,
  input  logic [DW-1:0]   src_l1_i,
  input  logic [DW-1:0]   src_map_i,
  input  logic [DW-1:0]   map_mask0_i,
  input  logic [DW-1:0]   map_mask1_i,
  input  logic [NTMR-1:0] tmr_lat_i,
  output logic [DW-1:0]   l0_stat_o,
  output logic [DW-1:0]   l1_stat_o
);
  always_comb begin
    l0_stat_o = src_l0_i;
    l0_stat_o[L0_MAP_BIT] = |(src_map_i & map_mask0_i);
    l1_stat_o = src_l1_i;
    l1_stat_o[L1_MAP_BIT] = |(src_map_i & map_mask1_i);
    l1_stat_o[L1_TMR_LSB +: NTMR] = tmr_lat_i;
  end
endmodule

// File: rtl/irq_cascade_out.sv
module irq_cascade_out
  import irq_cascade_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & mask_i);
  end

  // R1
  zero_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_o);
  // R9
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((stat_i & mask_i) != '0));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    src_l0_i,
  input  logic [7:0]    src_l1_i,
  input  logic [7:0]    src_map_i,
  input  logic [1:0]    tmr_evt_i,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic [1:0]    cpu_irq_o
);
  logic [DW-1:0] l0_mask, l1_mask, mm0, mm1, l0_stat, l1_stat;
  logic [NTMR-1:0] tmr_lat;
  logic [NBANK-1:0][DW-1:0] bank_stat, bank_mask;

  irq_cascade_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .tmr_evt_i,
    .l0_stat_i(l0_stat), .l1_stat_i(l1_stat), .map_stat_i(src_map_i),
    .l0_mask_o(l0_mask), .l1_mask_o(l1_mask),
    .map_mask0_o(mm0), .map_mask1_o(mm1),
    .tmr_lat_o(tmr_lat), .rdata_o(reg_rdata_o)
  );

  irq_cascade_status u_stat (
    .src_l0_i, .src_l1_i, .src_map_i,
    .map_mask0_i(mm0), .map_mask1_i(mm1), .tmr_lat_i(tmr_lat),
    .l0_stat_o(l0_stat), .l1_stat_o(l1_stat)
  );

  assign bank_stat = {l1_stat, l0_stat};
  assign bank_mask = {l1_mask, l0_mask};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_cascade_out u_out (
      .clk_i, .rst_ni,
      .stat_i(bank_stat[b]), .mask_i(bank_mask[b]),
      .irq_o(cpu_irq_o[b])
    );
  end

  // R5
  map0_cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_map_i & mm0) != '0) |-> l0_stat[L0_MAP_BIT]);
  // R6
  map1_cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_map_i & mm1) == '0) |-> !l1_stat[L1_MAP_BIT]);
endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
module irq_cascade_ctrl_tb_top;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src_l0 = '0, src_l1 = '0, src_map = '0;
  logic [1:0] tmr_evt = '0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_l0m = '0, m_l1m = '0, m_mm0 = '0, m_mm1 = '0;
  logic [1:0] m_tmr = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .src_l0_i(src_l0), .src_l1_i(src_l1), .src_map_i(src_map),
    .tmr_evt_i(tmr_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_irq_o(irq)
  );

  function automatic logic [7:0] exp_l0();
    return {|(src_map & m_mm0), src_l0[6:0]};
  endfunction

  function automatic logic [7:0] exp_l1();
    return {src_l1[7:6], m_tmr, |(src_map & m_mm1), src_l1[2:0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0: return exp_l0();
      4'h1: return m_l0m;
      4'h2: return exp_l1();
      4'h3: return m_l1m;
      4'h4: return src_map;
      4'h5: return m_mm0;
      4'h9: return m_mm1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one edge: predict irq from pre-edge model, advance model, compare at negedge
  task automatic tick();
    logic [1:0] e_irq;
    logic [1:0] clr;
    e_irq = {|(exp_l1() & m_l1m), |(exp_l0() & m_l0m)};
    clr = (we && addr == 4'h8) ? wdata[1:0] : 2'b00;
    @(posedge clk);
    m_tmr = (m_tmr & ~clr) | tmr_evt;
    if (we) begin
      case (addr)
        4'h1: m_l0m = wdata;
        4'h3: m_l1m = wdata;
        4'h5: m_mm0 = wdata;
        4'h9: m_mm1 = wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    we = 1'b0;
    tmr_evt = '0;
    check("R9 irq", {6'd0, irq}, {6'd0, e_irq});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    addr = a;
    #1;
    check(req, rdata, exp_rd(a));
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c4a7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 l0 mask", 4'h1); rd("R1 l1 mask", 4'h3);
    rd("R1 map mask0", 4'h5); rd("R1 map mask1", 4'h9);
    rd("R1 timer latches", 4'h2);
    check("R1 irq", {6'd0, irq}, 8'h00);

    // R2 / R3 raw levels, ignored positions
    src_l0 = 8'hff; src_l1 = 8'hff; src_map = 8'hff;
    rd("R2 l0 ignores bit7 input", 4'h0);
    rd("R3 l1 ignores bits 5:3 input", 4'h2);
    rd("R4 map status", 4'h4);
    check("R2 l0 value", rdata, 8'hff); // placeholder read of map, overwritten below
    rd("R2 l0 stat", 4'h0);
    check("R2 l0 bit7 low with zero mask", rdata, 8'h7f);
    rd("R3 l1 stat", 4'h2);
    check("R3 l1 exact", rdata, 8'hc7);

    // R5 / R6 cascade
    src_map = 8'h10;
    wr(4'h5, 8'h01); rd("R5 no overlap", 4'h0);
    wr(4'h5, 8'h10); rd("R5 overlap", 4'h0);
    check("R5 bit7 set", {7'd0, rdata[7]}, 8'h01);
    wr(4'h9, 8'hef); rd("R6 no overlap", 4'h2);
    wr(4'h9, 8'h30); rd("R6 overlap", 4'h2);
    check("R6 bit3 set", {7'd0, rdata[3]}, 8'h01);

    // R10 status writes ignored, unmapped reads zero
    wr(4'h0, 8'h5a); wr(4'h2, 8'ha5); wr(4'h4, 8'hff);
    rd("R10 l0 mask kept", 4'h1); rd("R10 map mask0 kept", 4'h5);
    rd("R10 map mask1 kept", 4'h9); rd("R10 l1 stat kept", 4'h2);
    rd("R10 unmapped", 4'h7); rd("R10 unmapped hi", 4'hf);

    // R7 / R8 timer latches
    src_l1 = 8'h00;
    tmr_evt = 2'b01; tick();
    tmr_evt = 2'b00; tick();
    rd("R7 tmr0 held", 4'h2);
    check("R7 bit4", {7'd0, rdata[4]}, 8'h01);
    tmr_evt = 2'b10; tick();
    rd("R7 both held", 4'h2);
    wr(4'h8, 8'h01); rd("R8 clear bit0 only", 4'h2);
    check("R8 bit5 kept", {6'd0, rdata[5:4]}, 8'h02);
    rd("R8 clr reads zero", 4'h8);
    tmr_evt = 2'b10; wr(4'h8, 8'h03);
    rd("R8 set beats clear", 4'h2);
    check("R8 bit5 after race", {6'd0, rdata[5:4]}, 8'h02);
    wr(4'h8, 8'h03); rd("R8 clear both", 4'h2);

    // R9 irq latency: mask then source
    wr(4'h1, 8'h00); wr(4'h3, 8'h00);
    src_l0 = 8'h00; src_l1 = 8'h00; src_map = 8'h00; tick();
    wr(4'h1, 8'h04); src_l0 = 8'h04; tick(); tick();
    wr(4'h3, 8'h10); tmr_evt = 2'b01; tick(); tick(); tick();
    wr(4'h8, 8'h01); tick();

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      src_l0 = 8'($urandom); src_l1 = 8'($urandom); src_map = 8'($urandom);
      tmr_evt = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      op = $urandom % 6;
      case (op)
        0: wr(4'($urandom % 16), 8'($urandom));
        1: wr(4'h8, 8'($urandom % 4));
        2: begin rd("R10 random read", 4'($urandom % 16)); tick(); end
        3: begin rd("R2 random l0", 4'h0); rd("R3 random l1", 4'h2); tick(); end
        4: begin rd("R5 random map", 4'h4); tick(); end
        default: tick();
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule